// File: doc/BRIEF.md
# Output Port Register with Atomic Bit Set and Clear

This block is a bank of general-purpose output lines controlled through a small word-addressed register bus. A single data word drives the output pins, one bit per line, and the line count equals the word width. Two extra write-only strobe words let software raise or drop individual lines without reading the data word first. A write to the raise strobe turns on each line whose write bit is 1. A write to the drop strobe turns off each line whose write bit is 1. No other line changes in either case.

Parameters choose the word width, whether the strobe pair exists, and the pin order. In normal order, line n follows data bit n. In reversed order, line 0 follows the most significant bit. A further parameter makes reads of the data word return the input pins through a two-flop synchronizer instead of the stored word. Reads are combinational. A write takes effect at the clock edge where it is presented.

Top module: `mmgpio`

## Requirements
- R1: A synchronous active-high reset clears the data word to zero, so every output pin is 0 after reset.
- R2: A write to word offset 0 (bus_addr = 0) loads all data bits from bus_wdata at the same clock edge.
- R3: With the strobe pair present, a write to offset 1 sets to 1 each data bit whose bus_wdata bit is 1 and leaves every other bit unchanged.
- R4: With the strobe pair present, a write to offset 2 clears to 0 each data bit whose bus_wdata bit is 1 and leaves every other bit unchanged.
- R5: With REVERSED = 0, pin_out[n] equals data bit n. With REVERSED = 1, pin_out[n] equals data bit WIDTH-1-n.
- R6: With SAMPLE_INPUTS = 0, a read of offset 0 returns the data word, including every change made through the strobes.
- R7: A read of offsets 1, 2 or 3 returns zero.
- R8: A write to offset 3 has no effect. When the strobe pair is absent (HAS_SETCLR = 0), writes to offsets 1 and 2 also have no effect.
- R9: WIDTH must be 8, 16, 32 or 64. Any other value stops elaboration.
- R10: With SAMPLE_INPUTS = 1, a read of offset 0 returns pin_in after two clock edges of synchronization. pin_in[n] appears at register bit n in normal order and at bit WIDTH-1-n in reversed order.
- R11: A cycle with bus_we = 0 leaves the data word unchanged, whatever the values on bus_addr and bus_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word offset: 0 data, 1 set strobe, 2 clear strobe, 3 unused |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data |
| pin_in | input | WIDTH | Input pins, sampled only when SAMPLE_INPUTS = 1 |
| pin_out | output | WIDTH | Output pins |

## Verification
The bench uses strobe masks that overlap bits already set, that are all zero, and that touch both end bits. A design that stored the mask instead of merging it, or inverted it on the wrong strobe, would show a wrong readback at once. It also writes to the unused offset, and to the strobe offsets on a build without strobes. A decoder that aliases those offsets onto the data word or a strobe would alter the output. A second instance with reversed order and input sampling checks pin ordering in both directions. It also checks the two-edge synchronizer delay: an ordering mistake would light the wrong end pin, and a delay that is short by one flop would show the input one edge early.

// File: rtl/mmgpio_pkg.sv
package mmgpio_pkg;

   typedef enum logic [1:0] {
      OFS_DATA = 2'd0,
      OFS_SET  = 2'd1,
      OFS_CLR  = 2'd2,
      OFS_NONE = 2'd3
   } reg_ofs_e;

   function automatic bit width_is_legal(input int w);
      return (w == 8) || (w == 16) || (w == 32) || (w == 64);
   endfunction

endpackage

// File: rtl/mmgpio_bitmap.sv
module mmgpio_bitmap #(
   parameter int WIDTH   = 32,
   parameter bit REVERSE = 1'b0
) (
   input  logic [WIDTH-1:0] src,
   output logic [WIDTH-1:0] dst
);
   localparam int TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (REVERSE) begin : g_rev
         assign dst[i] = src[TOP-i];
      end else begin : g_fwd
         assign dst[i] = src[i];
      end
   end
endmodule

// File: rtl/mmgpio_sync.sv
module mmgpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   initial begin
      if (STAGES < 2) $error("mmgpio_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

   // R10: output is the input seen two edges earlier
   p_sync_delay_r10: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, STAGES)));
endmodule

// File: rtl/mmgpio_store.sv
module mmgpio_store #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [WIDTH-1:0] wval,
   output logic [WIDTH-1:0] word
);
   logic [WIDTH-1:0] word_nxt;

   always_comb begin
      word_nxt = word;
      if (load_en)     word_nxt = wval;
      else if (set_en) word_nxt = word | wval;
      else if (clr_en) word_nxt = word & ~wval;
   end

   always_ff @(posedge clk) begin
      if (rst) word <= '0;
      else     word <= word_nxt;
   end

   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (word == '0));

   p_data_load_r2: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (word == $past(wval)));

   p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
      (set_en && !load_en) |=>
         ((word & $past(wval)) == $past(wval)) &&
         ((word & ~$past(wval)) == ($past(word) & ~$past(wval))));

   p_clear_bits_r4: assert property (@(posedge clk) disable iff (rst)
      (clr_en && !load_en && !set_en) |=>
         ((word & $past(wval)) == '0) &&
         ((word & ~$past(wval)) == ($past(word) & ~$past(wval))));

   p_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!load_en && !set_en && !clr_en) |=> $stable(word));

   p_one_strobe: assert property (@(posedge clk) disable iff (rst)
      $onehot0({load_en, set_en, clr_en}));
endmodule

// File: rtl/mmgpio.sv
module mmgpio
   import mmgpio_pkg::*;
#(
   parameter int WIDTH         = 32,
   parameter bit HAS_SETCLR    = 1'b1,
   parameter bit REVERSED      = 1'b0,
   parameter bit SAMPLE_INPUTS = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       bus_addr,
   input  logic             bus_we,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out
);
   localparam int SYNC_STAGES = 2;

   // R9: width check at elaboration
   if (!width_is_legal(WIDTH)) begin : g_bad_width
      $error("mmgpio: WIDTH must be 8, 16, 32 or 64");
   end

   reg_ofs_e         ofs;
   logic             load_en;
   logic             set_en;
   logic             clr_en;
   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] readback;

   assign ofs     = reg_ofs_e'(bus_addr);
   assign load_en = bus_we && (ofs == OFS_DATA);

   if (HAS_SETCLR) begin : g_strobes
      assign set_en = bus_we && (ofs == OFS_SET);
      assign clr_en = bus_we && (ofs == OFS_CLR);
   end else begin : g_no_strobes
      assign set_en = 1'b0;
      assign clr_en = 1'b0;
   end

   mmgpio_store #(.WIDTH(WIDTH)) u_store (
      .clk     (clk),
      .rst     (rst),
      .load_en (load_en),
      .set_en  (set_en),
      .clr_en  (clr_en),
      .wval    (bus_wdata),
      .word    (data_q)
   );

   mmgpio_bitmap #(.WIDTH(WIDTH), .REVERSE(REVERSED)) u_out_map (
      .src (data_q),
      .dst (pin_out)
   );

   if (SAMPLE_INPUTS) begin : g_sample
      logic [WIDTH-1:0] pins_sync;
      mmgpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
         .clk (clk),
         .rst (rst),
         .d   (pin_in),
         .q   (pins_sync)
      );
      mmgpio_bitmap #(.WIDTH(WIDTH), .REVERSE(REVERSED)) u_in_map (
         .src (pins_sync),
         .dst (readback)
      );
   end else begin : g_stored
      logic unused_pin_in;
      assign unused_pin_in = ^pin_in;
      assign readback      = data_q;
   end

   assign bus_rdata = (ofs == OFS_DATA) ? readback : '0;

   p_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (bus_addr != 2'd0) |-> (bus_rdata == '0));

   p_spare_ignored_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == 2'd3) |=> $stable(pin_out));

   if (!HAS_SETCLR) begin : g_chk_absent
      p_absent_strobes_r8: assert property (@(posedge clk) disable iff (rst)
         (bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> $stable(pin_out));
   end

   if (!SAMPLE_INPUTS) begin : g_chk_readback
      p_readback_follows_r6: assert property (@(posedge clk) disable iff (rst)
         (bus_addr == 2'd0) |-> ($countones(bus_rdata) == $countones(pin_out)));
   end
endmodule

// File: tb/tb_mmgpio.sv
`timescale 1ns/1ps
module tb_mmgpio;
   localparam int W  = 32;
   localparam int WB = 16;
   localparam int NV = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    addr = '0;
   logic          we = 1'b0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic [W-1:0]  pin_in = '0;
   logic [W-1:0]  pin_out;

   logic [1:0]    b_addr = '0;
   logic          b_we = 1'b0;
   logic [WB-1:0] b_wdata = '0;
   logic [WB-1:0] b_rdata;
   logic [WB-1:0] b_pin_in = '0;
   logic [WB-1:0] b_pin_out;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mmgpio #(.WIDTH(W), .HAS_SETCLR(1'b1), .REVERSED(1'b0), .SAMPLE_INPUTS(1'b0)) dut (
      .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out));

   mmgpio #(.WIDTH(WB), .HAS_SETCLR(1'b0), .REVERSED(1'b1), .SAMPLE_INPUTS(1'b1)) dut_b (
      .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_we(b_we), .bus_wdata(b_wdata),
      .bus_rdata(b_rdata), .pin_in(b_pin_in), .pin_out(b_pin_out));

   // vector table: offset, write data, expected data word afterwards
   localparam logic [1:0]   V_ADDR [NV] = '{2'd0, 2'd1, 2'd2, 2'd1, 2'd2,
                                            2'd1, 2'd3, 2'd0, 2'd2, 2'd0};
   localparam logic [W-1:0] V_DATA [NV] = '{32'hA5A5_0F0F, 32'h0000_F000, 32'hA500_000F,
                                            32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                                            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFE,
                                            32'h1234_5678};
   localparam logic [W-1:0] V_EXP  [NV] = '{32'hA5A5_0F0F, 32'hA5A5_FF0F, 32'h00A5_FF00,
                                            32'h00A5_FF00, 32'h0000_0000, 32'h8000_0001,
                                            32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0001,
                                            32'h1234_5678};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0; addr = 2'd0; wdata = '0;
      #1;
   endtask

   task automatic wr_b(input logic [1:0] a, input logic [WB-1:0] d);
      @(negedge clk);
      b_addr = a; b_wdata = d; b_we = 1'b1;
      @(negedge clk);
      b_we = 1'b0; b_addr = 2'd0; b_wdata = '0;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1 reset pins", pin_out, '0);
      chk("R1 reset readback", rdata, '0);
      chk("R1 reset pins b", b_pin_out, '0);

      // R2 R3 R4 R6 R8 table walk
      for (int i = 0; i < NV; i++) begin
         wr(V_ADDR[i], V_DATA[i]);
         chk("R2/R3/R4/R8 readback R6", rdata, V_EXP[i]);
         chk("R5 normal order pins", pin_out, V_EXP[i]);
      end

      // R7: other offsets read zero
      for (int a = 1; a < 4; a++) begin
         @(negedge clk); addr = 2'(a); #1;
         chk("R7 read of strobe/spare offset", rdata, '0);
      end
      addr = 2'd0;

      // R11: we low with data offset and garbage data
      @(negedge clk); addr = 2'd0; wdata = 32'hDEAD_BEEF; we = 1'b0;
      @(negedge clk); #1;
      chk("R11 no write keeps data", rdata, 32'h1234_5678);
      @(negedge clk); addr = 2'd1; wdata = 32'hFFFF_FFFF;
      @(negedge clk); addr = 2'd0; #1;
      chk("R11 no write on set offset", pin_out, 32'h1234_5678);

      // R5 reversed order on second instance
      wr_b(2'd0, 16'h0001);
      chk("R5 reversed pin of bit 0", b_pin_out, 16'h8000);
      wr_b(2'd0, 16'hC000);
      chk("R5 reversed pins of top bits", b_pin_out, 16'h0003);
      // R8: strobes absent, offsets 1 and 2 ignored
      wr_b(2'd1, 16'hFFFF);
      chk("R8 absent set ignored", b_pin_out, 16'h0003);
      wr_b(2'd2, 16'hFFFF);
      chk("R8 absent clear ignored", b_pin_out, 16'h0003);

      // R10: sampled inputs, reversed order, two-edge delay
      @(negedge clk); b_addr = 2'd0; b_pin_in = 16'h0001;
      @(negedge clk); #1;
      chk("R10 not visible after one edge", b_rdata, 16'h0000);
      @(negedge clk); #1;
      chk("R10 pin 0 at top bit", b_rdata, 16'h8000);
      b_pin_in = 16'hF001;
      repeat (2) @(negedge clk); #1;
      chk("R10 mapped input pattern", b_rdata, 16'h800F);

      // R1: reset in mid-run
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0; #1;
      chk("R1 reset clears pins", pin_out, '0);
      chk("R1 reset clears pins b", b_pin_out, '0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule